// File: doc/BRIEF.md
# Second-Level Interrupt Aggregator

This block gathers a parameterised set of interrupt sources (32 by default) behind a small synchronous register port. It drives a single combined request to an upstream interrupt controller. Each source has one bit in every register. A source reaches the output only when it is pending and not masked.

A build-time parameter picks one of two behaviours. In latched mode, a rising edge on a source sets a sticky pending bit. Software clears that bit by writing a one to an acknowledge register. In level mode, the pending view is simply the live input level, and no acknowledge register exists. In both modes the mask is never written directly. Software sets mask bits through one register and clears them through another, writing ones in either case. A third register reads the mask back.

Top module: `irq_l2_ctrl`

## Requirements
- R1: After reset every source is masked (mask reads all ones), all latched pending bits are zero, `irq_o` is 0 and `rd_data_o` is 0.
- R2: In latched mode, a 0-to-1 change of `src_i[n]` between two clock edges sets pending bit n. The bit stays set after the input falls. Pending bits read at offset 0x00.
- R3: In latched mode, writing data to the acknowledge register at offset 0x08 clears every pending bit whose data bit is 1. Data bits that are 0 leave their pending bits unchanged.
- R4: In latched mode, when a new rising edge and an acknowledge of the same bit land in the same cycle, the bit ends up set.
- R5: Writing ones to the mask-set register masks those sources. Its offset is 0x10 in latched mode and 0x08 in level mode. Zero bits change nothing, and an all-ones write masks every source in one access.
- R6: Writing ones to the mask-clear register unmasks those sources. Its offset is 0x14 in latched mode and 0x0C in level mode. Zero bits change nothing.
- R7: The mask readback register returns the current mask, with 1 meaning masked. Its offset is 0x0C in latched mode and 0x04 in level mode. Read data appears on `rd_data_o` one clock after the cycle in which `rd_en_i` is high.
- R8: `irq_o` is a register. One clock after pending and mask settle, it equals the OR over all sources of (pending AND NOT masked).
- R9: In latched mode, edges are captured whether or not the source is masked. A masked pending source raises `irq_o` once it is unmasked.
- R10: In level mode, offset 0x00 reads the live input levels. Pending follows the input with no acknowledge step: when the input drops, the request drops.
- R11: Reads of write-only registers and of unmapped offsets return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | NUM_SRC | Interrupt sources, already synchronous to clk |
| addr_i | input | ADDR_W | Register byte offset |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | NUM_SRC | Write data, one bit per source |
| rd_en_i | input | 1 | Read strobe |
| rd_data_o | output | NUM_SRC | Registered read data |
| irq_o | output | 1 | Combined request to the upstream controller |

## Verification
In latched mode, the edge capture and the acknowledge write can both target one pending bit in the same cycle. The bench first leaves a bit pending and lowers its input. In a single cycle it then raises the input again and writes a one for that bit to the acknowledge register. A readback must show the bit still set. A second acknowledge, with the input held high, must then clear it, which shows that a held level is not taken as a new edge.

// File: rtl/irq_l2_pkg.sv
package irq_l2_pkg;

  // Byte offsets of the register set; has_ack is 0 when no acknowledge exists.
  typedef struct packed {
    logic [7:0] stat;
    logic [7:0] ack;
    logic [7:0] mstat;
    logic [7:0] mset;
    logic [7:0] mclr;
    logic       has_ack;
  } regmap_t;

  function automatic regmap_t map_for(input bit latched);
    regmap_t m;
    if (latched) begin
      m.stat    = 8'h00;
      m.ack     = 8'h08;
      m.mstat   = 8'h0C;
      m.mset    = 8'h10;
      m.mclr    = 8'h14;
      m.has_ack = 1'b1;
    end else begin
      m.stat    = 8'h00;
      m.ack     = 8'hFF;
      m.mstat   = 8'h04;
      m.mset    = 8'h08;
      m.mclr    = 8'h0C;
      m.has_ack = 1'b0;
    end
    return m;
  endfunction

endpackage

// File: rtl/irq_l2_edge_latch.sv
module irq_l2_edge_latch #(
  parameter int NUM_SRC = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic [NUM_SRC-1:0] ack_i,
  output logic [NUM_SRC-1:0] stat_o
);
  logic [NUM_SRC-1:0] prev_q;
  logic [NUM_SRC-1:0] stat_q;
  logic [NUM_SRC-1:0] rise;

  assign rise = src_i & ~prev_q;

  // A fresh edge overrides an acknowledge of the same bit.
  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= '0;
      stat_q <= '0;
    end else begin
      prev_q <= src_i;
      stat_q <= (stat_q & ~ack_i) | rise;
    end
  end

  assign stat_o = stat_q;
endmodule

// File: rtl/irq_l2_mask.sv
module irq_l2_mask #(
  parameter int NUM_SRC = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] set_i,
  input  logic [NUM_SRC-1:0] clr_i,
  output logic [NUM_SRC-1:0] mask_o
);
  logic [NUM_SRC-1:0] mask_q;

  always_ff @(posedge clk) begin
    if (rst) mask_q <= '1;
    else     mask_q <= (mask_q | set_i) & ~clr_i;
  end

  assign mask_o = mask_q;
endmodule

// File: rtl/irq_l2_regs.sv
module irq_l2_regs
  import irq_l2_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int ADDR_W  = 8,
  parameter bit LATCHED = 1'b1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               wr_en_i,
  input  logic [NUM_SRC-1:0] wr_data_i,
  input  logic               rd_en_i,
  input  logic [NUM_SRC-1:0] stat_i,
  input  logic [NUM_SRC-1:0] mask_i,
  output logic [NUM_SRC-1:0] ack_o,
  output logic [NUM_SRC-1:0] set_o,
  output logic [NUM_SRC-1:0] clr_o,
  output logic [NUM_SRC-1:0] rd_data_o
);
  localparam regmap_t MAP = map_for(LATCHED);

  logic hit_ack, hit_set, hit_clr;
  logic [NUM_SRC-1:0] rd_q;

  assign hit_ack = MAP.has_ack && (addr_i == ADDR_W'(MAP.ack));
  assign hit_set = (addr_i == ADDR_W'(MAP.mset));
  assign hit_clr = (addr_i == ADDR_W'(MAP.mclr));

  assign ack_o = (wr_en_i && hit_ack) ? wr_data_i : '0;
  assign set_o = (wr_en_i && hit_set) ? wr_data_i : '0;
  assign clr_o = (wr_en_i && hit_clr) ? wr_data_i : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q <= '0;
    end else if (rd_en_i) begin
      if (addr_i == ADDR_W'(MAP.stat))       rd_q <= stat_i;
      else if (addr_i == ADDR_W'(MAP.mstat)) rd_q <= mask_i;
      else                                   rd_q <= '0;
    end
  end

  assign rd_data_o = rd_q;
endmodule

// File: rtl/irq_l2_ctrl.sv
module irq_l2_ctrl #(
  parameter int NUM_SRC = 32,
  parameter int ADDR_W  = 8,
  parameter bit LATCHED = 1'b1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               wr_en_i,
  input  logic [NUM_SRC-1:0] wr_data_i,
  input  logic               rd_en_i,
  output logic [NUM_SRC-1:0] rd_data_o,
  output logic               irq_o
);
  logic [NUM_SRC-1:0] ack_w, set_w, clr_w;
  logic [NUM_SRC-1:0] stat_w, mask_w;
  logic               irq_q;

  irq_l2_regs #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .LATCHED(LATCHED)) u_regs (
    .clk(clk), .rst(rst), .addr_i(addr_i), .wr_en_i(wr_en_i),
    .wr_data_i(wr_data_i), .rd_en_i(rd_en_i), .stat_i(stat_w),
    .mask_i(mask_w), .ack_o(ack_w), .set_o(set_w), .clr_o(clr_w),
    .rd_data_o(rd_data_o)
  );

  irq_l2_mask #(.NUM_SRC(NUM_SRC)) u_mask (
    .clk(clk), .rst(rst), .set_i(set_w), .clr_i(clr_w), .mask_o(mask_w)
  );

  generate
    if (LATCHED) begin : g_latched
      irq_l2_edge_latch #(.NUM_SRC(NUM_SRC)) u_latch (
        .clk(clk), .rst(rst), .src_i(src_i), .ack_i(ack_w), .stat_o(stat_w)
      );
    end else begin : g_level
      // ack_w is always zero here: the level map decodes no acknowledge.
      assign stat_w = src_i & ~ack_w;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |(stat_w & ~mask_w);
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/irq_l2_ctrl_chk.sv
module irq_l2_ctrl_chk
  import irq_l2_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int ADDR_W  = 8,
  parameter bit LATCHED = 1'b1
) (
  input logic               clk,
  input logic               rst,
  input logic [NUM_SRC-1:0] src_i,
  input logic [ADDR_W-1:0]  addr_i,
  input logic               wr_en_i,
  input logic [NUM_SRC-1:0] wr_data_i,
  input logic               rd_en_i,
  input logic [NUM_SRC-1:0] rd_data_o,
  input logic               irq_o,
  input logic [NUM_SRC-1:0] stat,
  input logic [NUM_SRC-1:0] mask
);
  localparam regmap_t MAP = map_for(LATCHED);

  logic               rst_d;
  logic               armed_q;
  logic [NUM_SRC-1:0] src_d;
  logic [NUM_SRC-1:0] rise_c;
  logic               rd_unmapped;

  always_ff @(posedge clk) begin
    rst_d   <= rst;
    src_d   <= src_i;
    armed_q <= !rst;
  end

  assign rise_c      = src_i & ~src_d;
  assign rd_unmapped = (addr_i != ADDR_W'(MAP.stat)) && (addr_i != ADDR_W'(MAP.mstat));

  // R1: state right after a reset cycle
  always @(posedge clk) begin
    if (rst_d === 1'b1 && rst === 1'b0) begin
      a_reset_state_r1: assert (&mask && !irq_o && rd_data_o == '0);
    end
  end

  p_mask_set_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && addr_i == ADDR_W'(MAP.mset)) |=> ((mask & $past(wr_data_i)) == $past(wr_data_i)));

  p_mask_clr_r6: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && addr_i == ADDR_W'(MAP.mclr)) |=> ((mask & $past(wr_data_i)) == '0));

  p_all_masked_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    (armed_q && (&mask) && (&$past(mask))) |-> !irq_o);

  p_unmapped_zero_r11: assert property (@(posedge clk) disable iff (rst)
    (rd_en_i && rd_unmapped) |=> (rd_data_o == '0));

  p_mask_readback_r7: assert property (@(posedge clk) disable iff (rst)
    (rd_en_i && addr_i == ADDR_W'(MAP.mstat)) |=> (rd_data_o == $past(mask)));

  generate
    if (LATCHED) begin : g_lat_chk
      p_edge_wins_r4: assert property (@(posedge clk) disable iff (rst)
        armed_q |=> ((stat & $past(rise_c)) == $past(rise_c)));
      p_sticky_r2: assert property (@(posedge clk) disable iff (rst)
        !(wr_en_i && addr_i == ADDR_W'(MAP.ack)) |=> ((stat & $past(stat)) == $past(stat)));
    end else begin : g_lvl_chk
      p_live_read_r10: assert property (@(posedge clk) disable iff (rst)
        (rd_en_i && addr_i == ADDR_W'(MAP.stat)) |=> (rd_data_o == $past(src_i)));
    end
  endgenerate
endmodule

bind irq_l2_ctrl irq_l2_ctrl_chk #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .LATCHED(LATCHED)) u_chk (
  .clk(clk), .rst(rst), .src_i(src_i), .addr_i(addr_i), .wr_en_i(wr_en_i),
  .wr_data_i(wr_data_i), .rd_en_i(rd_en_i), .rd_data_o(rd_data_o), .irq_o(irq_o),
  .stat(stat_w), .mask(mask_w)
);

// File: tb/irq_l2_ctrl_bench.sv
`timescale 1ns/1ps
module irq_l2_ctrl_bench;
  localparam int N = 32;
  localparam int A = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0] src_e = '0, src_l = '0;
  logic [A-1:0] addr = '0;
  logic [N-1:0] wdata = '0;
  logic wr_e = 1'b0, wr_l = 1'b0, rd_e = 1'b0, rd_l = 1'b0;
  logic [N-1:0] rdata_e, rdata_l;
  logic irq_e, irq_l;

  int checks = 0;
  int fails  = 0;

  typedef struct {
    bit          lvl;
    logic [N-1:0] exp;
    string       tag;
  } rd_item_t;
  rd_item_t sb[$];

  always #5 clk = ~clk;

  irq_l2_ctrl #(.NUM_SRC(N), .ADDR_W(A), .LATCHED(1'b1)) u_irq_l2_ctrl (
    .clk(clk), .rst(rst), .src_i(src_e), .addr_i(addr), .wr_en_i(wr_e),
    .wr_data_i(wdata), .rd_en_i(rd_e), .rd_data_o(rdata_e), .irq_o(irq_e)
  );

  irq_l2_ctrl #(.NUM_SRC(N), .ADDR_W(A), .LATCHED(1'b0)) u_irq_l2_ctrl_lvl (
    .clk(clk), .rst(rst), .src_i(src_l), .addr_i(addr), .wr_en_i(wr_l),
    .wr_data_i(wdata), .rd_en_i(rd_l), .rd_data_o(rdata_l), .irq_o(irq_l)
  );

  task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: each read strobe seen at an edge yields data 2 ns later.
  initial begin
    forever begin
      @(posedge clk);
      if (rd_e || rd_l) begin
        #2;
        if (sb.size() == 0) begin
          chk("SB unexpected read", 1, 0);
        end else begin
          rd_item_t it;
          it = sb.pop_front();
          chk(it.tag, it.lvl ? rdata_l : rdata_e, it.exp);
        end
      end
    end
  end

  task automatic wr(input bit lvl, input logic [A-1:0] a, input logic [N-1:0] d);
    @(negedge clk);
    addr = a; wdata = d;
    if (lvl) wr_l = 1'b1; else wr_e = 1'b1;
    @(negedge clk);
    wr_l = 1'b0; wr_e = 1'b0;
  endtask

  task automatic rd(input bit lvl, input logic [A-1:0] a, input logic [N-1:0] exp, input string tag);
    rd_item_t it;
    @(negedge clk);
    addr = a;
    it.lvl = lvl; it.exp = exp; it.tag = tag;
    sb.push_back(it);
    if (lvl) rd_l = 1'b1; else rd_e = 1'b1;
    @(negedge clk);
    rd_l = 1'b0; rd_e = 1'b0;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    idle(3);
    rst = 1'b0;
    idle(1);
    chk("R1 irq latched", irq_e, 0);
    chk("R1 irq level", irq_l, 0);
    chk("R1 rd_data", rdata_e, 0);
    rd(0, 8'h0C, 32'hFFFF_FFFF, "R1 R7 mask after reset");
    rd(0, 8'h00, 32'h0, "R1 pending after reset");

    // R2 R9: pulse source 3 while masked
    @(negedge clk); src_e[3] = 1'b1;
    @(negedge clk); src_e[3] = 1'b0;
    idle(2);
    rd(0, 8'h00, 32'h8, "R2 R9 sticky bit while masked");
    chk("R9 masked no irq", irq_e, 0);

    // R6 R9: unmask source 3
    wr(0, 8'h14, 32'h8);
    idle(2);
    chk("R9 R8 irq after unmask", irq_e, 1);
    rd(0, 8'h0C, 32'hFFFF_FFF7, "R6 R7 mask readback");

    // R3: zero write to ack has no effect, then a one clears
    wr(0, 8'h08, 32'h0);
    rd(0, 8'h00, 32'h8, "R3 zero ack keeps bit");
    wr(0, 8'h08, 32'h8);
    rd(0, 8'h00, 32'h0, "R3 ack clears bit");
    idle(1);
    chk("R8 irq drops after ack", irq_e, 0);

    // R4: edge and ack in the same cycle
    @(negedge clk); src_e[5] = 1'b1;
    @(negedge clk); src_e[5] = 1'b0;
    idle(1);
    rd(0, 8'h00, 32'h20, "R4 setup pending");
    @(negedge clk);
    src_e[5] = 1'b1; addr = 8'h08; wdata = 32'h20; wr_e = 1'b1;
    @(negedge clk);
    wr_e = 1'b0;
    rd(0, 8'h00, 32'h20, "R4 edge wins over ack");
    wr(0, 8'h08, 32'h20);
    rd(0, 8'h00, 32'h0, "R4 R3 held level is no new edge");
    @(negedge clk); src_e[5] = 1'b0;

    // R5 / R6 mask set and clear
    wr(0, 8'h10, 32'h8);
    rd(0, 8'h0C, 32'hFFFF_FFFF, "R5 mask set bit");
    wr(0, 8'h14, 32'hFFFF_FFFF);
    rd(0, 8'h0C, 32'h0, "R6 clear all");
    wr(0, 8'h10, 32'h0);
    rd(0, 8'h0C, 32'h0, "R5 zero set no effect");
    wr(0, 8'h10, 32'hFFFF_FFFF);
    rd(0, 8'h0C, 32'hFFFF_FFFF, "R5 all ones single access");

    // R11 unreadable offsets
    rd(0, 8'h04, 32'h0, "R11 unmapped 0x04");
    rd(0, 8'h08, 32'h0, "R11 ack reads zero");
    rd(0, 8'h10, 32'h0, "R11 mask set reads zero");
    rd(0, 8'h14, 32'h0, "R11 mask clear reads zero");
    rd(0, 8'h1C, 32'h0, "R11 unmapped 0x1C");

    // R10 level variant
    @(negedge clk); src_l = 32'hA5;
    idle(2);
    rd(1, 8'h00, 32'hA5, "R10 live level read");
    chk("R10 masked level no irq", irq_l, 0);
    wr(1, 8'h0C, 32'h4);
    idle(1);
    chk("R8 R6 level irq after unmask", irq_l, 1);
    rd(1, 8'h04, 32'hFFFF_FFFB, "R7 level mask readback");
    @(negedge clk); src_l = 32'hA1;
    idle(2);
    chk("R10 level irq follows input", irq_l, 0);
    wr(1, 8'h08, 32'h4);
    rd(1, 8'h04, 32'hFFFF_FFFF, "R5 R10 level mask set at 0x08");
    rd(1, 8'h14, 32'h0, "R11 level unmapped 0x14");

    idle(3);
    chk("SB drained", sb.size(), 0);
    finish_run();
  end
endmodule